// File: doc/BRIEF.md
# Masked-Write PHY Control Register Bank

This block is a small bank of PHY control registers on a plain memory-mapped bus with separate write and read strobes. Each register keeps 16 bits of state. A 32-bit write word carries its own per-bit write-enable mask: the upper half selects which bits of the lower half are written, and all other stored bits keep their value. Software can therefore change one field with one write, with no read-modify-write and no risk of clobbering a field another agent owns.

The bank has three implemented registers. They drive the OTG port suspend code, ID pull-up select and clock-output keep bit (register 0). They drive the suspend-bypass, charger-detect enable and charger-detect reset bits (register 1). They drive the host port suspend code, its charger-detect enable and reset bits and its clock-output keep bit (register 2). Each suspend code is also decoded into a single "port suspended" flag. A read returns the stored half in bits 15:0, with zeros above, one cycle after the read strobe.

Top module: `mwr_phy_ctrl_bank`

## Requirements
- R1: After reset, register 0 reads 0x0000_0052, register 1 reads 0x0000_8000 and register 2 reads 0x0000_0102. Both ports are therefore out of suspend and both charger-detect resets are high.
- R2: On a write to an implemented register, stored bit n (0..15) takes wdata bit n when wdata bit n+16 is 1, and keeps its value when that bit is 0.
- R3: A write whose upper 16 bits are all zero leaves the addressed register unchanged.
- R4: A read strobe in cycle t gives bus_rvalid high and bus_rdata = {16'h0000, stored bits} in cycle t+1. bus_rvalid is low in every cycle after a cycle with no read strobe.
- R5: A write to an address of 3 or more changes no register. A read of such an address returns 0x0000_0000.
- R6: Register 0 bits 8:0 hold the OTG suspend code. otg_suspended is 1 exactly when the code equals 0x1D9; the code 0x052 means the port is running.
- R7: Register 1 bit 12 is the suspend bypass, bit 14 is charger-detect enable and bit 15 is charger-detect reset. Each can be written alone without disturbing the other two.
- R8: Register 0 bit 11 is the ID pull-up select and bit 14 is the OTG clock-output keep bit. Register 2 bits 3:0 hold the host suspend code (0x9 means suspended, 0x2 means running), bit 7 is the host charger-detect enable, bit 8 is the host charger-detect reset and bit 9 is the host clock-output keep bit.
- R9: A read and a write to the same register in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W (4) | Register word index |
| bus_wdata | input | 32 | Write word: [31:16] bit mask, [15:0] data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| otg_susp_code | output | 9 | OTG suspend code |
| otg_suspended | output | 1 | OTG code equals the suspend value |
| otg_idpu_sel | output | 1 | ID pull-up select |
| otg_clk_keep | output | 1 | OTG clock-output keep |
| otg_susp_bypass | output | 1 | Suspend bypass select |
| otg_chg_en | output | 1 | OTG charger-detect enable |
| otg_chg_rst | output | 1 | OTG charger-detect reset |
| host_susp_code | output | 4 | Host suspend code |
| host_suspended | output | 1 | Host code equals the suspend value |
| host_chg_en | output | 1 | Host charger-detect enable |
| host_chg_rst | output | 1 | Host charger-detect reset |
| host_clk_keep | output | 1 | Host clock-output keep |

## Verification
The masked write is tried with full-field masks, with masks narrower than the data, with checkerboard masks and with an all-zero mask. This tells apart a design that honours the mask bit by bit from one that writes whole words or ignores the mask. Single-bit writes to the charger-detect register show whether neighbouring bits survive. Writes and reads to unmapped addresses, followed by readback of every register, show that the decode is exact. A write and a read to the same register in one cycle shows the read-before-write ordering.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef logic [HALF_W-1:0] half_t;

    // register indices
    localparam int OTG_IDX   = 0;
    localparam int STRAP_IDX = 1;
    localparam int HOST_IDX  = 2;
    localparam int MIN_REGS  = 3;

    // OTG register fields
    localparam int            OTG_SUSP_LSB = 0;
    localparam int            OTG_SUSP_W   = 9;
    localparam logic [8:0]    OTG_SUSP_ON  = 9'h1D9;
    localparam logic [8:0]    OTG_SUSP_OFF = 9'h052;
    localparam int            IDPU_BIT     = 11;
    localparam int            OTG_CLK_BIT  = 14;

    // strap / charger register fields
    localparam int BYPASS_BIT  = 12;
    localparam int CHG_EN_BIT  = 14;
    localparam int CHG_RST_BIT = 15;

    // host register fields
    localparam int          HOST_SUSP_LSB = 0;
    localparam int          HOST_SUSP_W   = 4;
    localparam logic [3:0]  HOST_SUSP_ON  = 4'h9;
    localparam logic [3:0]  HOST_SUSP_OFF = 4'h2;
    localparam int          HOST_CHG_EN_BIT  = 7;
    localparam int          HOST_CHG_RST_BIT = 8;
    localparam int          HOST_CLK_BIT     = 9;

    typedef struct packed {
        half_t val;
    } lane_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              valid;
    } rd_state_t;

    function automatic half_t reset_word(input int idx);
        half_t w;
        w = '0;
        case (idx)
            OTG_IDX:   w[OTG_SUSP_LSB +: OTG_SUSP_W] = OTG_SUSP_OFF;
            STRAP_IDX: w[CHG_RST_BIT] = 1'b1;
            HOST_IDX: begin
                w[HOST_SUSP_LSB +: HOST_SUSP_W] = HOST_SUSP_OFF;
                w[HOST_CHG_RST_BIT] = 1'b1;
            end
            default:   w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/mwr_decode.sv
module mwr_decode #(
    parameter int ADDR_W   = 4,
    parameter int NUM_REGS = 3
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_REGS-1:0] wr_sel,
    output logic              rd_hit
);
    localparam logic [ADDR_W:0] REG_COUNT = (ADDR_W+1)'(NUM_REGS);

    logic [ADDR_W:0] addr_ext;
    assign addr_ext = {1'b0, addr};

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_sel
            assign wr_sel[gi] = wr_en && (addr_ext == (ADDR_W+1)'(gi));
        end
    endgenerate

    assign rd_hit = rd_en && (addr_ext < REG_COUNT);

endmodule

// File: rtl/mwr_lane.sv
module mwr_lane
    import mwr_pkg::*;
#(
    parameter half_t RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wdata,
    output half_t             val_q
);
    lane_state_t st_d, st_q;
    half_t       mask, data;

    assign mask = wdata[WORD_W-1:HALF_W];
    assign data = wdata[HALF_W-1:0];

    always_comb begin
        st_d = st_q;
        if (wr_sel) begin
            st_d.val = (st_q.val & ~mask) | (data & mask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.val <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign val_q = st_q.val;

    AST_ZERO_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sel && (mask == '0)) |=> $stable(val_q)); // R3

    AST_UNMASKED_BITS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> ((val_q & ~$past(mask)) == ($past(val_q) & ~$past(mask)))); // R2

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(val_q)); // R5

endmodule

// File: rtl/mwr_rdport.sv
module mwr_rdport
    import mwr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_REGS = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic                       rd_hit,
    input  logic [ADDR_W-1:0]          rd_idx,
    input  logic [NUM_REGS*HALF_W-1:0] reg_flat,
    output logic [WORD_W-1:0]          rdata,
    output logic                       rvalid
);
    rd_state_t st_d, st_q;
    half_t     word;

    always_comb begin
        word = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == ADDR_W'(i)) begin
                word = reg_flat[i*HALF_W +: HALF_W];
            end
        end
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = rd_en;
        if (rd_en) begin
            st_d.data = rd_hit ? {{HALF_W{1'b0}}, word} : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.data;
    assign rvalid = st_q.valid;

    AST_RVALID_TRACKS_RD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid); // R4

    AST_NO_RD_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid); // R4

endmodule

// File: rtl/mwr_phy_ctrl_bank.sv
module mwr_phy_ctrl_bank
    import mwr_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int NUM_REGS = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic [8:0]        otg_susp_code,
    output logic              otg_suspended,
    output logic              otg_idpu_sel,
    output logic              otg_clk_keep,
    output logic              otg_susp_bypass,
    output logic              otg_chg_en,
    output logic              otg_chg_rst,
    output logic [3:0]        host_susp_code,
    output logic              host_suspended,
    output logic              host_chg_en,
    output logic              host_chg_rst,
    output logic              host_clk_keep
);
    localparam logic [ADDR_W:0] REG_COUNT = (ADDR_W+1)'(NUM_REGS);

    logic [NUM_REGS-1:0]        wr_sel;
    logic                       rd_hit;
    half_t                      reg_val [NUM_REGS];
    logic [NUM_REGS*HALF_W-1:0] reg_flat;

    mwr_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_decode (
        .wr_en  (bus_wr),
        .rd_en  (bus_rd),
        .addr   (bus_addr),
        .wr_sel (wr_sel),
        .rd_hit (rd_hit)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_lane
            mwr_lane #(
                .RST_VAL (reset_word(gi))
            ) u_lane (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_sel (wr_sel[gi]),
                .wdata  (bus_wdata),
                .val_q  (reg_val[gi])
            );
            assign reg_flat[gi*HALF_W +: HALF_W] = reg_val[gi];
        end
    endgenerate

    mwr_rdport #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_rdport (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (bus_rd),
        .rd_hit   (rd_hit),
        .rd_idx   (bus_addr),
        .reg_flat (reg_flat),
        .rdata    (bus_rdata),
        .rvalid   (bus_rvalid)
    );

    // field map
    assign otg_susp_code   = reg_val[OTG_IDX][OTG_SUSP_LSB +: OTG_SUSP_W];
    assign otg_suspended   = (otg_susp_code == OTG_SUSP_ON);
    assign otg_idpu_sel    = reg_val[OTG_IDX][IDPU_BIT];
    assign otg_clk_keep    = reg_val[OTG_IDX][OTG_CLK_BIT];
    assign otg_susp_bypass = reg_val[STRAP_IDX][BYPASS_BIT];
    assign otg_chg_en      = reg_val[STRAP_IDX][CHG_EN_BIT];
    assign otg_chg_rst     = reg_val[STRAP_IDX][CHG_RST_BIT];
    assign host_susp_code  = reg_val[HOST_IDX][HOST_SUSP_LSB +: HOST_SUSP_W];
    assign host_suspended  = (host_susp_code == HOST_SUSP_ON);
    assign host_chg_en     = reg_val[HOST_IDX][HOST_CHG_EN_BIT];
    assign host_chg_rst    = reg_val[HOST_IDX][HOST_CHG_RST_BIT];
    assign host_clk_keep   = reg_val[HOST_IDX][HOST_CLK_BIT];

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)); // R5

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && ({1'b0, bus_addr} >= REG_COUNT)) |=> (bus_rdata == 32'h0)); // R5

    AST_READ_OLD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_addr == ADDR_W'(OTG_IDX)))
        |=> (bus_rdata == {16'h0000, $past(reg_val[OTG_IDX])})); // R9

endmodule

// File: tb/sim_mwr_phy_ctrl_bank.sv
`timescale 1ns/1ps
module sim_mwr_phy_ctrl_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [8:0]  otg_susp_code;
    logic        otg_suspended, otg_idpu_sel, otg_clk_keep, otg_susp_bypass;
    logic        otg_chg_en, otg_chg_rst;
    logic [3:0]  host_susp_code;
    logic        host_suspended, host_chg_en, host_chg_rst, host_clk_keep;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] model [0:2];
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    mwr_phy_ctrl_bank u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .otg_susp_code(otg_susp_code),
        .otg_suspended(otg_suspended), .otg_idpu_sel(otg_idpu_sel),
        .otg_clk_keep(otg_clk_keep), .otg_susp_bypass(otg_susp_bypass),
        .otg_chg_en(otg_chg_en), .otg_chg_rst(otg_chg_rst),
        .host_susp_code(host_susp_code), .host_suspended(host_suspended),
        .host_chg_en(host_chg_en), .host_chg_rst(host_chg_rst),
        .host_clk_keep(host_clk_keep)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one bus cycle, pushes expected read data into the scoreboard
    task automatic cyc(input logic wr, input logic rd, input logic [3:0] a,
                       input logic [31:0] d, input string tag);
        @(negedge clk);
        if (rd) begin
            exp_q.push_back((a < 4'd3) ? {16'h0000, model[a]} : 32'h0);
            tag_q.push_back(tag);
        end
        if (wr && a < 4'd3)
            model[a] = (model[a] & ~d[31:16]) | (d[15:0] & d[31:16]);
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    endtask

    task automatic wr_settle(input logic [3:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d, "");
        idle();
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 4'(i), 32'h0, tag);
        idle();
    endtask

    // monitor: pops and compares read results
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (bus_rvalid) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R4: unexpected rvalid, actual %h expected none", bus_rdata);
                end else begin
                    chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model[0] = 16'h0052; model[1] = 16'h8000; model[2] = 16'h0102;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 otg code", {23'h0, otg_susp_code}, 32'h052);
        chk("R1 otg suspended", {31'h0, otg_suspended}, 32'h0);
        chk("R1 chg rst", {30'h0, otg_chg_rst, host_chg_rst}, 32'h3);
        chk("R1 host code", {28'h0, host_susp_code}, 32'h2);
        chk("R4 rvalid idle", {31'h0, bus_rvalid}, 32'h0);
        rd_all("R1 reset readback");

        // R6 OTG suspend code
        wr_settle(4'd0, 32'h01FF_01D9);
        chk("R6 otg suspended", {31'h0, otg_suspended}, 32'h1);
        chk("R6 otg code", {23'h0, otg_susp_code}, 32'h1D9);
        wr_settle(4'd0, 32'h01FF_0052);
        chk("R6 otg resumed", {31'h0, otg_suspended}, 32'h0);

        // R8 OTG single bits
        wr_settle(4'd0, 32'h0800_0800);
        chk("R8 idpu", {31'h0, otg_idpu_sel}, 32'h1);
        chk("R8 code kept", {23'h0, otg_susp_code}, 32'h052);
        wr_settle(4'd0, 32'h4000_4000);
        chk("R8 otg clk keep", {31'h0, otg_clk_keep}, 32'h1);

        // R2 narrow and checkerboard masks
        wr_settle(4'd0, 32'h00F0_FFFF);
        cyc(1'b0, 1'b1, 4'd0, 32'h0, "R2 narrow mask");
        wr_settle(4'd2, 32'hAAAA_5555);
        cyc(1'b0, 1'b1, 4'd2, 32'h0, "R2 checker mask A");
        wr_settle(4'd2, 32'h5555_FFFF);
        cyc(1'b0, 1'b1, 4'd2, 32'h0, "R2 checker mask B");
        idle();

        // R3 zero mask
        wr_settle(4'd1, 32'h0000_FFFF);
        cyc(1'b0, 1'b1, 4'd1, 32'h0, "R3 zero mask");
        idle();

        // R7 charger bits independence
        wr_settle(4'd1, 32'h4000_4000);
        chk("R7 chg en set", {29'h0, otg_chg_en, otg_chg_rst, otg_susp_bypass}, 32'h6);
        wr_settle(4'd1, 32'h8000_0000);
        chk("R7 chg rst clear", {29'h0, otg_chg_en, otg_chg_rst, otg_susp_bypass}, 32'h4);
        wr_settle(4'd1, 32'h1000_1000);
        chk("R7 bypass set", {29'h0, otg_chg_en, otg_chg_rst, otg_susp_bypass}, 32'h5);

        // R8 host fields
        wr_settle(4'd2, 32'h038F_0009);
        chk("R8 host suspended", {31'h0, host_suspended}, 32'h1);
        chk("R8 host bits", {29'h0, host_chg_en, host_chg_rst, host_clk_keep}, 32'h0);
        wr_settle(4'd2, 32'h0380_0380);
        chk("R8 host bits set", {29'h0, host_chg_en, host_chg_rst, host_clk_keep}, 32'h7);
        wr_settle(4'd2, 32'h000F_0002);
        chk("R8 host resumed", {31'h0, host_suspended}, 32'h0);

        // R5 unmapped addresses
        wr_settle(4'd3, 32'hFFFF_FFFF);
        wr_settle(4'd15, 32'hFFFF_0000);
        cyc(1'b0, 1'b1, 4'd3, 32'h0, "R5 unmapped read 3");
        cyc(1'b0, 1'b1, 4'd15, 32'h0, "R5 unmapped read 15");
        idle();
        rd_all("R5 regs untouched");

        // R9 read and write in the same cycle
        cyc(1'b1, 1'b1, 4'd2, 32'hFFFF_1234, "R9 read before write");
        cyc(1'b0, 1'b1, 4'd2, 32'h0, "R9 new value");
        idle();

        repeat (3) idle();
        chk("R4 all reads returned", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule